// File: doc/BRIEF.md
# 100BASE-TX Receive Decode Path

This block is the digital back end of a fast-Ethernet receiver. Each cycle of a single 125 MHz clock it takes one recovered line symbol, given as a three-level MLT-3 value. It turns the symbol stream into NRZI and then into plain NRZ bits. It removes the line scrambling and finds the code-group boundaries from the start-of-stream pair. It then turns each 5-bit code group into a 4-bit nibble, flagged with receive-valid and receive-error. Equalization, baseline correction and clock recovery happen upstream and are not part of this block.

A control word from the PHY register file drives the block. Its bit 14 selects an internal loopback. In loopback the local transmit NRZI stream replaces the converted line stream at the input of the NRZ conversion, so only the MLT-3 stage is bypassed. A flag tells the transmit side to keep sending idle on the line while loopback is active.

Top module: `fx_rx_decode`

## Requirements
- R1: The MLT-3 input is coded 2'b01 = +1, 2'b00 = 0, 2'b11 = -1. The internal NRZI bit inverts on every cycle whose level differs from the level of the previous cycle. Its reset level is 0 and the previous level at reset is 0.
- R2: The NRZ bit is 1 when the selected NRZI bit differs from the NRZI bit of the previous cycle, and 0 otherwise. The previous NRZI bit is 0 at reset.
- R3: The descrambler keeps an 11-bit key register. The key bit is the XOR of its bits 10 and 8 (polynomial x^11 + x^9 + 1). The plain bit is the received NRZ bit XOR the key bit. Once locked, the key bit is shifted in at bit 0 every cycle.
- R4: Before lock, the complement of each received bit is shifted into the key register. Lock is declared after 32 consecutive cycles in which the predicted key bit equals that complement. Lock holds until reset. No frame can start before lock.
- R5: Outside a frame, the pair 11000 then 10001 (leftmost bit received first) starts a frame. Every following 5 bits form one code group, and rx_dv rises with the first group after the pair.
- R6: Data groups decode as 11110=0, 01001=1, 10100=2, 10101=3, 01010=4, 01011=5, 01110=6, 01111=7, 10010=8, 10011=9, 10110=A, 10111=B, 11010=C, 11011=D, 11100=E, 11101=F. On the line path, the outputs change on the clock edge after the edge that samples a group's last MLT-3 symbol, and they hold until the next group.
- R7: Inside a frame, group 01101 or group 11111 ends the frame. In that group rx_dv, rx_er and rxd all return to 0.
- R8: Inside a frame, any other group that is not a data code gives rx_dv=1, rx_er=1 and rxd=0 for that group.
- R9: When ctrl_word bit 14 is 1, tx_nrzi feeds the NRZ stage and mlt3_lvl has no effect. The outputs then change on the same edge that samples a group's last tx_nrzi bit. When bit 14 is 0, tx_nrzi has no effect. No other ctrl_word bit affects the block.
- R10: line_send_idle equals ctrl_word bit 14.
- R11: While rst_n is low at a clock edge, rxd, rx_dv and rx_er are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mlt3_lvl | input | 2 | Recovered line symbol level (R1 coding) |
| tx_nrzi | input | 1 | Local transmit NRZI bit used in loopback |
| ctrl_word | input | 16 | PHY control word; bit 14 selects loopback |
| rxd | output | 4 | Decoded receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error for the current nibble |
| line_send_idle | output | 1 | Tells the transmitter to send only idle on the line |

## Verification
The embedded assertions assume a well-formed MLT-3 input: the level is never 2'b10, and it never moves straight between +1 and -1 without passing through 0. The bench therefore always builds the line symbols with a legal MLT-3 encoder. This holds even in loopback, where it drives an unrelated random-walk symbol sequence to show that the line is ignored. The bench scrambles every frame with its own key register started from a nonzero seed. It precedes each frame with a long idle run so the descrambler can lock, and it places one deliberate frame inside the lock window to show that no frame starts before lock.

// File: rtl/fx_rx_pkg.sv
// Shared constants and code-group decode for the 100BASE-TX receive path.
// Assumes 5-bit code groups and 4-bit nibbles, leftmost bit received first.
package fx_rx_pkg;

    localparam int CG_W  = 5;
    localparam int NIB_W = 4;

    localparam logic [2*CG_W-1:0] SSD_PAIR = 10'b11000_10001;
    localparam logic [CG_W-1:0]   CG_END   = 5'b01101;
    localparam logic [CG_W-1:0]   CG_IDLE  = 5'b11111;

    typedef struct packed {
        logic             ok;
        logic [NIB_W-1:0] nib;
    } cg_dec_t;

    // Map one code group to a data nibble; ok is low for non-data groups.
    function automatic cg_dec_t cg_decode(input logic [CG_W-1:0] cg);
        cg_dec_t r;
        r.ok = 1'b1;
        case (cg)
            5'b11110: r.nib = 4'h0;
            5'b01001: r.nib = 4'h1;
            5'b10100: r.nib = 4'h2;
            5'b10101: r.nib = 4'h3;
            5'b01010: r.nib = 4'h4;
            5'b01011: r.nib = 4'h5;
            5'b01110: r.nib = 4'h6;
            5'b01111: r.nib = 4'h7;
            5'b10010: r.nib = 4'h8;
            5'b10011: r.nib = 4'h9;
            5'b10110: r.nib = 4'hA;
            5'b10111: r.nib = 4'hB;
            5'b11010: r.nib = 4'hC;
            5'b11011: r.nib = 4'hD;
            5'b11100: r.nib = 4'hE;
            5'b11101: r.nib = 4'hF;
            default: begin
                r.ok  = 1'b0;
                r.nib = 4'h0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fx_mlt3_nrzi.sv
// MLT-3 to NRZI converter.
// Takes one signed three-level symbol per clock and inverts the NRZI bit
// whenever the level moves. Assumes the upstream slicer only produces legal
// MLT-3 (no 2'b10 code, no direct +1 <-> -1 step).
module fx_mlt3_nrzi #(
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl,
    output logic             nrzi
);

    logic [LVL_W-1:0] lvl_q;

    // Remember last level and invert the NRZI bit on every level change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            nrzi  <= 1'b0;
        end else begin
            lvl_q <= lvl;
            if (lvl != lvl_q)
                nrzi <= ~nrzi;
        end
    end

    // R1: input coding never uses the unassigned code
    a_r1_legal_level: assert property (@(posedge clk) disable iff (!rst_n)
        lvl != 2'b10)
        else $error("a_r1_legal_level: illegal MLT-3 code");

    // R1: MLT-3 only steps between adjacent levels
    a_r1_adjacent_step: assert property (@(posedge clk) disable iff (!rst_n)
        !((lvl_q == 2'b01 && lvl == 2'b11) || (lvl_q == 2'b11 && lvl == 2'b01)))
        else $error("a_r1_adjacent_step: level jumped across zero");

endmodule

// File: rtl/fx_nrzi_nrz.sv
// Loopback select and NRZI to NRZ conversion.
// The loopback bit picks the local transmit NRZI stream in place of the
// line-derived one; the NRZ bit marks a transition against the last cycle.
module fx_nrzi_nrz (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    input  logic line_nrzi,
    input  logic tx_nrzi,
    output logic nrz
);

    logic sel_nrzi;
    logic prev_nrzi;

    // Choose the source stream feeding the converter.
    always_comb sel_nrzi = loop_en ? tx_nrzi : line_nrzi;

    // Hold the previous NRZI bit for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_nrzi <= 1'b0;
        else        prev_nrzi <= sel_nrzi;
    end

    // A transition is a one, no transition is a zero.
    always_comb nrz = sel_nrzi ^ prev_nrzi;

endmodule

// File: rtl/fx_descrambler.sv
// Self-synchronising descrambler, polynomial x^11 + x^9 + 1.
// Assumes the line sends idle (plain ones) long enough after reset for the
// key register to be loaded from the stream. Outputs ones until locked.
module fx_descrambler #(
    parameter int LFSR_W   = 11,
    parameter int TAP_HI   = 10,
    parameter int TAP_LO   = 8,
    parameter int LOCK_RUN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scr_bit,
    output logic plain_bit,
    output logic locked
);

    localparam int CW = $clog2(LOCK_RUN + 1);

    logic [LFSR_W-1:0] key_q;
    logic [CW-1:0]     run_q;
    logic              key_bit;
    logic              hit;

    // Predicted key bit and whether idle would explain the received bit.
    always_comb begin
        key_bit = key_q[TAP_HI] ^ key_q[TAP_LO];
        hit     = (key_bit == ~scr_bit);
    end

    // Load from the stream until a full run of hits, then free-run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= '0;
            run_q  <= '0;
            locked <= 1'b0;
        end else if (locked) begin
            key_q <= {key_q[LFSR_W-2:0], key_bit};
        end else begin
            key_q <= {key_q[LFSR_W-2:0], ~scr_bit};
            if (!hit)
                run_q <= '0;
            else if (run_q == CW'(LOCK_RUN - 1))
                locked <= 1'b1;
            else
                run_q <= run_q + 1'b1;
        end
    end

    // Unscramble once locked; present idle ones before that.
    always_comb plain_bit = locked ? (scr_bit ^ key_bit) : 1'b1;

    // R4: lock is kept until reset
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked)
        else $error("a_r4_lock_sticky: lock lost");

endmodule

// File: rtl/fx_cg_align.sv
// Code-group aligner and 5B/4B decoder.
// Finds the start-of-stream pair, then cuts every 5 bits into a group and
// decodes it into registered nibble, valid and error outputs held per group.
module fx_cg_align
    import fx_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er
);

    localparam int PH_W = $clog2(CG_W);

    logic [2*CG_W-1:0] sh;
    logic [2*CG_W-1:0] sh_nx;
    logic [PH_W-1:0]   ph;
    logic              in_frame;
    logic              grp_done;
    logic              is_end;
    cg_dec_t           dec;

    // Window of recent bits, current group and its decode.
    always_comb begin
        sh_nx    = {sh[2*CG_W-2:0], bit_in};
        grp_done = in_frame && (ph == PH_W'(CG_W - 1));
        is_end   = (sh_nx[CG_W-1:0] == CG_END) || (sh_nx[CG_W-1:0] == CG_IDLE);
        dec      = cg_decode(sh_nx[CG_W-1:0]);
    end

    // Track framing and update outputs once per completed group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '1;
            ph       <= '0;
            in_frame <= 1'b0;
            rxd      <= '0;
            rx_dv    <= 1'b0;
            rx_er    <= 1'b0;
        end else begin
            sh <= sh_nx;
            if (!in_frame) begin
                if (sh_nx == SSD_PAIR) begin
                    in_frame <= 1'b1;
                    ph       <= '0;
                end
            end else if (grp_done) begin
                ph <= '0;
                if (is_end) begin
                    in_frame <= 1'b0;
                    rx_dv    <= 1'b0;
                    rx_er    <= 1'b0;
                    rxd      <= '0;
                end else begin
                    rx_dv <= 1'b1;
                    rx_er <= ~dec.ok;
                    rxd   <= dec.ok ? dec.nib : '0;
                end
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    // R8: an error is only flagged inside valid data
    a_r8_er_needs_dv: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> rx_dv)
        else $error("a_r8_er_needs_dv: rx_er without rx_dv");

    // R6: outputs hold between group boundaries
    a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_done |=> $stable({rx_dv, rx_er, rxd}))
        else $error("a_r6_hold_between: output changed mid-group");

    // R5: valid only rises once framing is established
    a_r5_dv_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> $past(in_frame))
        else $error("a_r5_dv_after_pair: rx_dv rose outside a frame");

    // R5: the group phase stays inside one group
    a_r5_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        ph < PH_W'(CG_W))
        else $error("a_r5_phase_range: phase out of range");

    // R7: an end or idle group closes the frame
    a_r7_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_done && is_end) |=> (!rx_dv && !in_frame))
        else $error("a_r7_end_closes: frame not closed");

endmodule

// File: rtl/fx_rx_decode.sv
// 100BASE-TX receive decode path, top level.
// One recovered MLT-3 symbol per 125 MHz clock in, MII-style nibble out.
// Assumes a single clock domain and a symbol stream already equalised and
// retimed. A control-word bit selects internal loopback of transmit NRZI.
module fx_rx_decode #(
    parameter int CTRL_W   = 16,
    parameter int LOOP_BIT = 14,
    parameter int LVL_W    = 2,
    parameter int LFSR_W   = 11,
    parameter int TAP_HI   = 10,
    parameter int TAP_LO   = 8,
    parameter int LOCK_RUN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  mlt3_lvl,
    input  logic              tx_nrzi,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic [3:0]        rxd,
    output logic              rx_dv,
    output logic              rx_er,
    output logic              line_send_idle
);

    logic loop_en;
    logic line_nrzi;
    logic nrz_bit;
    logic plain_bit;
    logic scr_locked;
    logic unused_ctrl;

    // Decode the loopback control bit; other bits belong to other logic.
    always_comb begin
        loop_en        = ctrl_word[LOOP_BIT];
        line_send_idle = loop_en;
        unused_ctrl    = ^ctrl_word;
    end

    fx_mlt3_nrzi #(.LVL_W(LVL_W)) u_mlt3 (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (mlt3_lvl),
        .nrzi  (line_nrzi)
    );

    fx_nrzi_nrz u_nrz (
        .clk       (clk),
        .rst_n     (rst_n),
        .loop_en   (loop_en),
        .line_nrzi (line_nrzi),
        .tx_nrzi   (tx_nrzi),
        .nrz       (nrz_bit)
    );

    fx_descrambler #(
        .LFSR_W   (LFSR_W),
        .TAP_HI   (TAP_HI),
        .TAP_LO   (TAP_LO),
        .LOCK_RUN (LOCK_RUN)
    ) u_dscr (
        .clk       (clk),
        .rst_n     (rst_n),
        .scr_bit   (nrz_bit),
        .plain_bit (plain_bit),
        .locked    (scr_locked)
    );

    fx_cg_align u_align (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (plain_bit),
        .rxd    (rxd),
        .rx_dv  (rx_dv),
        .rx_er  (rx_er)
    );

    // R4: no frame is reported while the descrambler is unlocked
    a_r4_no_dv_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !scr_locked |-> !rx_dv)
        else $error("a_r4_no_dv_unlocked: data valid before lock");

endmodule

// File: tb/tb_fx_rx_decode.sv
// Bench for the receive decode path: scrambles and line-codes frames,
// models the expected nibble stream behaviourally and compares every clock.
module tb_fx_rx_decode;

    localparam int CLK_PERIOD = 8;
    localparam int LOCK_RUN   = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mlt3_lvl = 2'b00;
    logic       tx_nrzi = 1'b0;
    logic [15:0] ctrl_word = 16'h0000;
    logic [3:0] rxd;
    logic       rx_dv, rx_er, line_send_idle;

    fx_rx_decode dut (
        .clk(clk), .rst_n(rst_n), .mlt3_lvl(mlt3_lvl), .tx_nrzi(tx_nrzi),
        .ctrl_word(ctrl_word), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
        .line_send_idle(line_send_idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        bit       upd;
        bit       dv;
        bit       er;
        bit [3:0] nib;
    } ev_t;

    bit [4:0] code_of [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};

    int       total = 0;
    int       bad   = 0;
    bit       done  = 0;
    ev_t      pend[$];
    bit       exp_dv, exp_er;
    bit [3:0] exp_nib;
    int       lat;
    bit       loop_mode;
    bit [10:0] scr = 11'h5A3;
    bit       enc_nrzi;
    int       lvl_idx, noise_idx;
    bit [9:0] win;
    bit       m_frame;
    int       m_ph;
    bit [4:0] m_grp;
    int       bitno;
    string    tag;

    function automatic bit [1:0] lvl_code(int idx);
        case (idx)
            1:       return 2'b01;
            3:       return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] expv, string what);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
        end
    endtask

    // Behavioural framing model on the plain bit stream.
    function automatic ev_t model_bit(bit p);
        ev_t e = '0;
        bit  found = 0;
        win = {win[8:0], p};
        if (!m_frame) begin
            if (bitno > LOCK_RUN && win == 10'b1100010001) begin
                m_frame = 1;
                m_ph = 0;
            end
        end else begin
            m_grp = {m_grp[3:0], p};
            m_ph++;
            if (m_ph == 5) begin
                m_ph = 0;
                e.upd = 1;
                if (m_grp == 5'b01101 || m_grp == 5'b11111) begin
                    m_frame = 0;
                end else begin
                    for (int i = 0; i < 16; i++)
                        if (code_of[i] == m_grp) begin
                            found = 1;
                            e.nib = i[3:0];
                        end
                    e.dv = 1;
                    e.er = !found;
                end
            end
        end
        return e;
    endfunction

    // One bit time: compare outputs, then drive the next symbol.
    task automatic step(bit p);
        ev_t e;
        bit  key, s;
        if (pend.size() == lat) begin
            e = pend.pop_front();
            if (e.upd) begin
                exp_dv = e.dv; exp_er = e.er; exp_nib = e.nib;
            end
        end
        check(tag, rx_dv, exp_dv, "rx_dv");
        check(tag, rx_er, exp_er, "rx_er");
        check(tag, rxd, exp_nib, "rxd");
        check("R10", line_send_idle, loop_mode, "line_send_idle");
        key = scr[10] ^ scr[8];
        s = p ^ key;
        scr = {scr[9:0], key};
        if (s) begin
            enc_nrzi = ~enc_nrzi;
            lvl_idx = (lvl_idx + 1) % 4;
        end
        if (loop_mode) begin
            tx_nrzi = enc_nrzi;
            if ($urandom_range(1, 0) == 1) noise_idx = (noise_idx + 1) % 4;
            mlt3_lvl = lvl_code(noise_idx);
        end else begin
            mlt3_lvl = lvl_code(lvl_idx);
            tx_nrzi = $urandom_range(1, 0) == 1;
        end
        bitno++;
        pend.push_back(model_bit(p));
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_group(bit [4:0] g);
        for (int i = 4; i >= 0; i--) step(g[i]);
    endtask

    task automatic send_idle(int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic send_frame(int n);
        send_group(5'b11000);
        send_group(5'b10001);
        for (int i = 0; i < n; i++) send_group(code_of[$urandom_range(15, 0)]);
        send_group(5'b01101);
        send_group(5'b00111);
    endtask

    task automatic do_reset(bit [15:0] ctrl);
        @(negedge clk);
        rst_n = 0;
        ctrl_word = ctrl;
        mlt3_lvl = 2'b00;
        tx_nrzi = 1'b0;
        loop_mode = ctrl[14];
        lat = loop_mode ? 1 : 2;
        repeat (3) @(negedge clk);
        check("R11", rx_dv, 0, "rx_dv in reset");
        check("R11", rx_er, 0, "rx_er in reset");
        check("R11", rxd, 0, "rxd in reset");
        check("R10", line_send_idle, loop_mode, "line_send_idle in reset");
        pend.delete();
        exp_dv = 0; exp_er = 0; exp_nib = 0;
        enc_nrzi = 0; lvl_idx = 0; noise_idx = 0;
        win = '0; m_frame = 0; m_ph = 0; m_grp = '0; bitno = 0;
        rst_n = 1;
    endtask

    initial begin
        // Line path, frame inside the lock window must not appear (R4).
        do_reset(16'h0000);
        tag = "R4 prelock frame";
        send_idle(2);
        send_group(5'b11000);
        send_group(5'b10001);
        send_group(code_of[5]);
        send_group(5'b01101);
        send_group(5'b00111);
        send_idle(130);
        // All sixteen data codes through the full line path.
        tag = "R1 R2 R3 R5 R6 line decode";
        send_group(5'b11000);
        send_group(5'b10001);
        for (int i = 0; i < 16; i++) send_group(code_of[i]);
        send_group(5'b01101);
        send_group(5'b00111);
        send_idle(20);
        // Invalid groups mid-frame, frame closed by idle.
        tag = "R8 R7 bad groups";
        send_group(5'b11000);
        send_group(5'b10001);
        send_group(code_of[3]);
        send_group(5'b00000);
        send_group(code_of[10]);
        send_group(5'b11000);
        send_group(5'b00100);
        send_group(code_of[7]);
        send_group(5'b11111);
        send_idle(20);
        tag = "R6 R7 random frame";
        send_frame(20);
        send_idle(15);
        // Loopback: line symbols are noise, data comes from tx_nrzi.
        do_reset(16'h4000);
        tag = "R9 loopback";
        send_idle(120);
        send_frame(12);
        send_idle(20);
        // Unrelated control bits leave the line path selected.
        do_reset(16'hA0C1);
        tag = "R9 R10 other ctrl bits";
        send_idle(120);
        send_frame(8);
        send_idle(20);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule